// File: doc/BRIEF.md
# External Bus Cycle Engine

This block sits between an on-chip requester and an external memory bus. Each internal read or write is turned into one or two pin-level bus cycles whose shape depends on the address. Five programmable address windows are compared with the request address. The window that matches picks how the cycle looks: shared or separate address/data ports, 8-bit or 16-bit data, ALE pulse length, strobe delay, wait states, and whether a slow device may stretch the cycle with READY. An address outside every enabled window uses a default mode.

The requester holds `req_valid` and its fields steady until `req_ack` pulses for one clock. Read data is valid on `req_rdata` in that clock. A 16-bit access to an 8-bit window becomes two back-to-back byte cycles with a single acknowledge. A global setting picks 16, 18, 20 or 23 external address bits. A segmented flag decides whether the bits from A16 upward leave the block at all.

Top module: `extbus_engine`

## Requirements
- R1: A window hits when it is enabled and `(addr & mask) == (base & mask)`. The lowest-numbered hitting window sets the mode. With no hit, `cfg_dflt_mode` applies. The mode layout is: bit 8 multiplexed, bit 7 16-bit width, bit 6 two-clock ALE, bit 5 one-clock strobe delay, bit 4 READY enable, bits 3:0 wait count.
- R2: In demultiplexed mode, `ext_addr` carries the low 16 address bits from ALE through the hold clock and is stable while a strobe is active. `ext_ad_out` never carries the address, and `ext_ad_oe` stays low for reads.
- R3: In multiplexed mode, `ext_ad_out` carries the low 16 address bits with `ext_ad_oe` high while ALE is high, and `ext_addr` is zero. No strobe overlaps ALE.
- R4: ALE stays high for 1 clock, or for 2 clocks when the two-clock bit is set. It is never high for more than 2 clocks in a row.
- R5: The first strobe clock follows the last ALE clock at once, or one clock later when the strobe-delay bit is set.
- R6: A strobe lasts wait count + 1 clocks when READY is not enabled.
- R7: With READY enabled, once the wait clocks have passed, READY is sampled on every clock. The strobe ends on the first edge at which READY is high.
- R8: In an 8-bit window, `req_be` bit 0 selects the even byte (address bit 0 = 0) and bit 1 selects the odd byte (address bit 0 = 1). Both set gives two cycles, even byte first, with one acknowledge. Byte data uses `ext_ad_out[7:0]` and `ext_ad_in[7:0]`, and `ext_ad_out[15:8]` is zero in the data phase. A 16-bit window always runs one cycle with address bit 0 forced to zero.
- R9: `cfg_aw_sel` 0/1/2/3 selects 16/18/20/23 address bits. `ext_seg` carries address bits 16 and up, masked to the selected width, and is zero whenever `cfg_segmented` is low.
- R10: Read data is taken from `ext_ad_in` on the edge that ends RD. Write data stays on `ext_ad_out`, with `ext_ad_oe` high, for one clock after WR falls.
- R11: RD and WR are never high together, and `req_ack` is a single-clock pulse.
- R12: During and after reset, with no request, all strobes, ALE, output enable, `req_ack` and the address/data outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_win_base | input | NWIN*AW | Window base addresses, window i at bits i*AW |
| cfg_win_mask | input | NWIN*AW | Window compare masks |
| cfg_win_en | input | NWIN | Window enables |
| cfg_win_mode | input | NWIN*9 | Window modes, window i at bits i*9 |
| cfg_dflt_mode | input | 9 | Mode used when no window hits |
| cfg_aw_sel | input | 2 | External address width select |
| cfg_segmented | input | 1 | Drive upper address bits |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables |
| req_ack | output | 1 | Access complete pulse |
| req_rdata | output | 16 | Read data, valid with acknowledge |
| ext_addr | output | 16 | Separate address port (demultiplexed) |
| ext_seg | output | AW-16 | Upper address port |
| ext_ad_out | output | 16 | Data or shared address/data out |
| ext_ad_oe | output | 1 | Output enable for ext_ad_out |
| ext_ad_in | input | 16 | Data in |
| ext_ale | output | 1 | Address latch enable |
| ext_rd | output | 1 | Read strobe, active high |
| ext_wr | output | 1 | Write strobe, active high |
| ext_ready | input | 1 | Device ready |

## Verification
The assertions assume the requester keeps `req_valid` and its fields steady until the acknowledge, and lowers `req_valid` in the acknowledge clock. They also assume the configuration inputs change only while the engine is idle. The bench changes window settings, width selection and the segmented flag only between accesses. It drops the request on the same falling edge at which it sees `req_ack`. It moves READY only while a strobe is active and leaves it high at all other times. Read data is driven only during strobe clocks and is filler at all other times, so a capture on the wrong edge shows up in the returned word.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
package ebc_pkg;
  localparam int MODE_W = 9;

  typedef struct packed {
    logic       mux;
    logic       wide;
    logic       ale2;
    logic       sdly;
    logic       rdy_en;
    logic [3:0] waits;
  } bus_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_DLY,
    ST_STB,
    ST_HOLD
  } bus_st_t;
endpackage

// File: rtl/ebc_window_sel.sv
`timescale 1ns/1ps
module ebc_window_sel
  import ebc_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int AW   = 23
) (
  input  logic [AW-1:0]          addr,
  input  logic [NWIN*AW-1:0]     base,
  input  logic [NWIN*AW-1:0]     mask,
  input  logic [NWIN-1:0]        en,
  input  logic [NWIN*MODE_W-1:0] modes,
  input  logic [MODE_W-1:0]      dflt,
  output bus_mode_t              sel
);
  logic [NWIN-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_cmp
      assign hit[g] = en[g] &&
        ((addr & mask[g*AW +: AW]) == (base[g*AW +: AW] & mask[g*AW +: AW]));
    end
  endgenerate

  // lowest index has priority: scan from the top so it is written last
  always_comb begin
    sel = bus_mode_t'(dflt);
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) sel = bus_mode_t'(modes[i*MODE_W +: MODE_W]);
    end
  end
endmodule

// File: rtl/ebc_addr_fmt.sv
`timescale 1ns/1ps
module ebc_addr_fmt #(
  parameter int AW = 23
) (
  input  logic [AW-2:0]  word_addr,
  input  logic           lane,
  input  logic           wide,
  input  logic [1:0]     aw_sel,
  input  logic           segmented,
  output logic [15:0]    lo,
  output logic [AW-17:0] hi
);
  localparam int HW = AW - 16;

  logic [AW-1:0] full;
  logic [HW-1:0] hmask;
  int            nbits;

  always_comb begin
    full = {word_addr, (wide ? 1'b0 : lane)};
    case (aw_sel)
      2'd0:    nbits = 0;
      2'd1:    nbits = 2;
      2'd2:    nbits = 4;
      default: nbits = HW;
    endcase
    for (int b = 0; b < HW; b++) hmask[b] = (b < nbits);
    lo = full[15:0];
    hi = segmented ? (full[AW-1:16] & hmask) : '0;
  end
endmodule

// File: rtl/extbus_engine.sv
`timescale 1ns/1ps
module extbus_engine
  import ebc_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int AW   = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWIN*AW-1:0]       cfg_win_base,
  input  logic [NWIN*AW-1:0]       cfg_win_mask,
  input  logic [NWIN-1:0]          cfg_win_en,
  input  logic [NWIN*MODE_W-1:0]   cfg_win_mode,
  input  logic [MODE_W-1:0]        cfg_dflt_mode,
  input  logic [1:0]               cfg_aw_sel,
  input  logic                     cfg_segmented,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [15:0]              req_wdata,
  input  logic [1:0]               req_be,
  output logic                     req_ack,
  output logic [15:0]              req_rdata,
  output logic [15:0]              ext_addr,
  output logic [AW-17:0]           ext_seg,
  output logic [15:0]              ext_ad_out,
  output logic                     ext_ad_oe,
  input  logic [15:0]              ext_ad_in,
  output logic                     ext_ale,
  output logic                     ext_rd,
  output logic                     ext_wr,
  input  logic                     ext_ready
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bus_mode_t     win_mode, mode_q;
  bus_st_t       st_q, st_d;
  logic [3:0]    cnt_q, cnt_d;
  logic          lane_q, lane_d, pend_q, pend_d;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q, rbuf_q, data_out;
  logic          load, cap, in_data, ale_drv;
  logic [15:0]   a_lo;
  logic [AW-17:0] a_hi;

  ebc_window_sel #(.NWIN(NWIN), .AW(AW)) u_sel (
    .addr  (req_addr),
    .base  (cfg_win_base),
    .mask  (cfg_win_mask),
    .en    (cfg_win_en),
    .modes (cfg_win_mode),
    .dflt  (cfg_dflt_mode),
    .sel   (win_mode)
  );

  ebc_addr_fmt #(.AW(AW)) u_fmt (
    .word_addr (addr_q[AW-1:1]),
    .lane      (lane_q),
    .wide      (mode_q.wide),
    .aw_sel    (cfg_aw_sel),
    .segmented (cfg_segmented),
    .lo        (a_lo),
    .hi        (a_hi)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    lane_d  = lane_q;
    pend_d  = pend_q;
    load    = 1'b0;
    cap     = 1'b0;
    req_ack = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          load   = 1'b1;
          st_d   = ST_ALE;
          cnt_d  = win_mode.ale2 ? 4'd1 : 4'd0;
          lane_d = !win_mode.wide && !req_be[0] && req_be[1];
          pend_d = !win_mode.wide && req_be[0] && req_be[1];
        end
      end
      ST_ALE: begin
        if (cnt_q != 4'd0) begin
          cnt_d = cnt_q - 4'd1;
        end else if (mode_q.sdly) begin
          st_d = ST_DLY;
        end else begin
          st_d  = ST_STB;
          cnt_d = mode_q.waits;
        end
      end
      ST_DLY: begin
        st_d  = ST_STB;
        cnt_d = mode_q.waits;
      end
      ST_STB: begin
        if (cnt_q != 4'd0) begin
          cnt_d = cnt_q - 4'd1;
        end else if (!mode_q.rdy_en || ext_ready) begin
          cap  = !wr_q;
          st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (pend_q) begin
          pend_d = 1'b0;
          lane_d = 1'b1;
          st_d   = ST_ALE;
          cnt_d  = mode_q.ale2 ? 4'd1 : 4'd0;
        end else begin
          req_ack = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      lane_q  <= 1'b0;
      pend_q  <= 1'b0;
      mode_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbuf_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lane_q <= lane_d;
      pend_q <= pend_d;
      if (load) begin
        mode_q  <= win_mode;
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (load) begin
        rbuf_q <= '0;
      end else if (cap) begin
        if (mode_q.wide)  rbuf_q       <= ext_ad_in;
        else if (lane_q)  rbuf_q[15:8] <= ext_ad_in[7:0];
        else              rbuf_q[7:0]  <= ext_ad_in[7:0];
      end
    end
  end

  // pin outputs
  always_comb begin
    in_data  = (st_q == ST_DLY) || (st_q == ST_STB) || (st_q == ST_HOLD);
    ale_drv  = mode_q.mux && (st_q == ST_ALE);
    data_out = mode_q.wide ? wdata_q
                           : {8'h00, (lane_q ? wdata_q[15:8] : wdata_q[7:0])};
    ext_ale    = (st_q == ST_ALE);
    ext_rd     = (st_q == ST_STB) && !wr_q;
    ext_wr     = (st_q == ST_STB) && wr_q;
    ext_ad_oe  = ale_drv || (wr_q && in_data);
    ext_ad_out = ale_drv ? a_lo : ((wr_q && in_data) ? data_out : 16'h0000);
    ext_addr   = (!mode_q.mux && (st_q != ST_IDLE)) ? a_lo : 16'h0000;
    ext_seg    = (st_q != ST_IDLE) ? a_hi : '0;
  end

  assign req_rdata = rbuf_q;
endmodule

// File: rtl/ebc_checker.sv
`timescale 1ns/1ps
module ebc_checker #(
  parameter int AW = 23
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_segmented,
  input logic           req_ack,
  input logic           ext_ale,
  input logic           ext_rd,
  input logic           ext_wr,
  input logic           ext_ad_oe,
  input logic [15:0]    ext_addr,
  input logic [AW-17:0] ext_seg
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));  // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);  // R11
  AST_ALE_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ale && $past(ext_ale)) |=> !ext_ale);  // R4
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> (!ext_rd && !ext_wr));  // R3
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_wr) |-> ext_ad_oe);  // R10
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> !ext_ad_oe);  // R2
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && $past(ext_rd || ext_wr)) |-> $stable(ext_addr));  // R2
  AST_SEG_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_segmented |-> (ext_seg == '0));  // R9
endmodule

bind extbus_engine ebc_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_segmented (cfg_segmented),
  .req_ack       (req_ack),
  .ext_ale       (ext_ale),
  .ext_rd        (ext_rd),
  .ext_wr        (ext_wr),
  .ext_ad_oe     (ext_ad_oe),
  .ext_addr      (ext_addr),
  .ext_seg       (ext_seg)
);

// File: tb/tb_extbus_engine.sv
`timescale 1ns/1ps
module tb_extbus_engine;
  localparam int NWIN = 5;
  localparam int AW   = 23;

  logic clk, rst_n;
  logic [NWIN*AW-1:0] cfg_win_base, cfg_win_mask;
  logic [NWIN-1:0]    cfg_win_en;
  logic [NWIN*9-1:0]  cfg_win_mode;
  logic [8:0]         cfg_dflt_mode;
  logic [1:0]         cfg_aw_sel;
  logic               cfg_segmented;
  logic               req_valid, req_write, req_ack;
  logic [AW-1:0]      req_addr;
  logic [15:0]        req_wdata, req_rdata;
  logic [1:0]         req_be;
  logic [15:0]        ext_addr, ext_ad_out, ext_ad_in;
  logic [AW-17:0]     ext_seg;
  logic               ext_ad_oe, ext_ale, ext_rd, ext_wr, ext_ready;

  int total = 0;
  int bad   = 0;

  extbus_engine #(.NWIN(NWIN), .AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // observation record of one access
  int          n_ale, nruns, first_stb, ack_cnt, hold_bad, oe_total, ack_at;
  logic [15:0] ale_ad, cur_a, got_rd;
  logic [22:0] stb_full [4];
  logic [15:0] stb_wd   [4];
  int          run_len  [4];

  function automatic logic [15:0] pat(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic logic [8:0] mk(input logic mux, wide, ale2, sdly, rdy,
                                    input logic [3:0] w);
    return {mux, wide, ale2, sdly, rdy, w};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [22:0] a,
                        input logic [15:0] wd, input logic [1:0] be,
                        input int rdy_at);
    logic prev_stb, prev_wr, prev_ale, stb;
    int   k;
    n_ale = 0; nruns = 0; first_stb = -1; ack_cnt = 0; hold_bad = 0;
    oe_total = 0; ack_at = -1; ale_ad = '0; cur_a = '0; got_rd = '0; k = 0;
    for (int j = 0; j < 4; j++) begin
      stb_full[j] = '0; stb_wd[j] = '0; run_len[j] = 0;
    end
    prev_stb = 1'b0; prev_wr = 1'b0; prev_ale = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    for (int i = 1; i < 120 && ack_cnt == 0; i++) begin
      @(negedge clk);
      if (ext_ad_oe) oe_total++;
      if (ext_ale) begin
        if (!prev_ale) begin
          if (n_ale == 0) ale_ad = ext_ad_out;
          cur_a = ext_ad_oe ? ext_ad_out : ext_addr;
        end
        n_ale++;
      end
      stb = ext_rd || ext_wr;
      if (stb) begin
        if (!prev_stb) begin
          if (first_stb < 0) first_stb = i;
          if (nruns < 4) begin
            stb_full[nruns] = {ext_seg, ext_addr};
            stb_wd[nruns]   = ext_ad_out;
          end
          nruns++;
          k = 0;
        end
        k++;
        if (nruns <= 4) run_len[nruns-1]++;
        ext_ad_in = pat(cur_a);
        ext_ready = (k >= rdy_at);
      end else begin
        ext_ad_in = 16'hDEAD;
        ext_ready = 1'b1;
      end
      if (prev_wr && !ext_wr && !ext_ad_oe) hold_bad++;
      if (req_ack) begin
        ack_cnt++; ack_at = i; got_rd = req_rdata; req_valid = 1'b0;
      end
      prev_stb = stb; prev_wr = ext_wr; prev_ale = ext_ale;
    end
  endtask

  task automatic t_reset;
    chk("R12", "ack", req_ack, 0);
    chk("R12", "ale/rd/wr", {ext_ale, ext_rd, ext_wr}, 0);
    chk("R12", "oe", ext_ad_oe, 0);
    chk("R12", "addr/seg/ad", {ext_seg, ext_addr, ext_ad_out}, 0);
  endtask

  task automatic t_demux_read;
    access(1'b0, 23'h001234, 16'h0, 2'b11, 1);
    chk("R1", "window0 strobe length", run_len[0], 3);
    chk("R6", "wait states 2 -> 3 strobe clocks", run_len[0], 3);
    chk("R5", "no delay: first strobe", first_stb, 2);
    chk("R2", "demux address on addr port", stb_full[0], 23'h001234);
    chk("R2", "data port never driven on read", oe_total, 0);
    chk("R10", "read data", got_rd, pat(16'h1234));
    chk("R11", "ack clock", ack_at, 5);
  endtask

  task automatic t_mux_write;
    access(1'b1, 23'h002468, 16'hBEEF, 2'b11, 1);
    chk("R4", "two-clock ALE", n_ale, 2);
    chk("R3", "address on shared port", ale_ad, 16'h2468);
    chk("R5", "delay: first strobe", first_stb, 4);
    chk("R6", "zero waits", run_len[0], 1);
    chk("R3", "addr port idle in mux", stb_full[0], 0);
    chk("R10", "write data", stb_wd[0], 16'hBEEF);
    chk("R10", "data held after WR", hold_bad, 0);
    chk("R11", "single ack", ack_cnt, 1);
  endtask

  task automatic t_overlap;
    access(1'b0, 23'h001900, 16'h0, 2'b11, 1);
    chk("R1", "overlap lowest wins: length", run_len[0], 3);
    chk("R1", "overlap lowest wins: demux", oe_total, 0);
    chk("R10", "read data", got_rd, pat(16'h1900));
  endtask

  task automatic t_default;
    access(1'b0, 23'h010000, 16'h0, 2'b11, 1);
    chk("R1", "default length", run_len[0], 6);
    chk("R4", "default ALE", n_ale, 2);
    chk("R5", "default first strobe", first_stb, 3);
    chk("R9", "23-bit segmented address", stb_full[0], 23'h010000);
    chk("R10", "read data", got_rd, pat(16'h0000));
  endtask

  task automatic t_narrow_read;
    access(1'b0, 23'h003010, 16'h0, 2'b11, 1);
    chk("R8", "two byte cycles", nruns, 2);
    chk("R8", "even byte first", stb_full[0], 23'h003010);
    chk("R8", "odd byte second", stb_full[1], 23'h003011);
    chk("R8", "one ack", ack_cnt, 1);
    chk("R6", "byte cycle waits", run_len[1], 2);
    chk("R8", "assembled word", got_rd,
        {pat(16'h3011) & 16'h00FF, 8'h00} >> 0 | {8'h00, pat(16'h3010)[7:0]});
  endtask

  task automatic t_narrow_write;
    access(1'b1, 23'h003020, 16'hA55A, 2'b10, 1);
    chk("R8", "odd only: one cycle", nruns, 1);
    chk("R8", "odd byte address", stb_full[0], 23'h003021);
    chk("R8", "high byte on low lane", stb_wd[0], 16'h00A5);
  endtask

  task automatic t_ready;
    access(1'b0, 23'h004000, 16'h0, 2'b01, 7);
    chk("R7", "stretched strobe", run_len[0], 7);
    chk("R5", "mux delay first strobe", first_stb, 3);
    chk("R10", "byte read", got_rd, {8'h00, pat(16'h4000)[7:0]});
    access(1'b0, 23'h004000, 16'h0, 2'b01, 1);
    chk("R7", "ready early: wait count rules", run_len[0], 4);
  endtask

  task automatic t_width;
    cfg_aw_sel = 2'd1;
    access(1'b0, 23'h7F1234, 16'h0, 2'b11, 1);
    chk("R9", "18-bit address", stb_full[0], 23'h031234);
    cfg_aw_sel = 2'd2;
    access(1'b0, 23'h7F1234, 16'h0, 2'b11, 1);
    chk("R9", "20-bit address", stb_full[0], 23'h0F1234);
    cfg_segmented = 1'b0;
    access(1'b0, 23'h7F1234, 16'h0, 2'b11, 1);
    chk("R9", "non-segmented address", stb_full[0], 23'h001234);
    cfg_segmented = 1'b1; cfg_aw_sel = 2'd3;
  endtask

  task automatic t_disable;
    cfg_win_en[2] = 1'b0;
    access(1'b0, 23'h003010, 16'h0, 2'b11, 1);
    chk("R1", "disabled window: single cycle", nruns, 1);
    chk("R1", "disabled window: default length", run_len[0], 6);
    cfg_win_en[2] = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_be = 2'b11; ext_ad_in = 16'hDEAD; ext_ready = 1'b1;
    cfg_aw_sel = 2'd3; cfg_segmented = 1'b1; cfg_win_en = '1;
    cfg_win_base = '0; cfg_win_mask = '0; cfg_win_mode = '0;
    cfg_win_base[0*AW +: AW] = 23'h001000; cfg_win_mask[0*AW +: AW] = 23'h7FF000;
    cfg_win_mode[0*9 +: 9]   = mk(0, 1, 0, 0, 0, 4'd2);
    cfg_win_base[1*AW +: AW] = 23'h002000; cfg_win_mask[1*AW +: AW] = 23'h7FF000;
    cfg_win_mode[1*9 +: 9]   = mk(1, 1, 1, 1, 0, 4'd0);
    cfg_win_base[2*AW +: AW] = 23'h003000; cfg_win_mask[2*AW +: AW] = 23'h7FF000;
    cfg_win_mode[2*9 +: 9]   = mk(0, 0, 0, 0, 0, 4'd1);
    cfg_win_base[3*AW +: AW] = 23'h004000; cfg_win_mask[3*AW +: AW] = 23'h7FF000;
    cfg_win_mode[3*9 +: 9]   = mk(1, 0, 0, 1, 1, 4'd3);
    cfg_win_base[4*AW +: AW] = 23'h001800; cfg_win_mask[4*AW +: AW] = 23'h7FF800;
    cfg_win_mode[4*9 +: 9]   = mk(1, 1, 0, 0, 0, 4'd7);
    cfg_dflt_mode = mk(0, 1, 1, 0, 0, 4'd5);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_demux_read;
    t_mux_write;
    t_overlap;
    t_default;
    t_narrow_read;
    t_narrow_write;
    t_ready;
    t_width;
    t_disable;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule